// File: doc/BRIEF.md
# Bus-Readable 32 kHz Free-Running Counter

This block counts ticks of a slow 32.768 kHz reference (0x8000 ticks per second) in a 32-bit register. Software reads the count through a small request/response register bus clocked by the fast bus clock. The slow tick arrives as an asynchronous level. It is brought into the bus clock domain by a flop chain, and each rising edge becomes a single-cycle count enable. The count restarts from zero at reset, so it always gives the ticks elapsed since reset, and it wraps silently at the top of its range.

Two registers can be read: a fixed revision word and the live count. A processor with a 16-bit data path can read the count in two halves. Reading the lower half stores the upper half of the same sample in a holding register, and the following upper-half read returns that stored value. The two halves therefore always belong to the same sample, even when a carry crosses bit 16 between the two reads. Writes of any width, byte-wide accesses and reads of unknown offsets answer with an error strobe and zero data. They alter nothing.

Every request is answered exactly one clock later with a one-cycle response.

Top module: `sync_tick_counter`

## Requirements
- R1: Each rising edge of `tick_async`, held for at least one bus clock, adds exactly one to the count. A level held high for many cycles counts once. The new count is readable no later than four bus clocks after the edge.
- R2: While `rst` is high, the count and the holding register are cleared, and `rsp_valid`, `rsp_err` and `rsp_data` are zero.
- R3: Each request (`req` high for one cycle) produces `rsp_valid` high for exactly one cycle, on the clock after the request. `rsp_valid` is low otherwise.
- R4: A word read (`size` = 2'b10) at offset 0x010 returns the full 32-bit count, sampled at the clock that takes the request.
- R5: A read at offset 0x000 returns the revision value 0x21. As a word read it returns 0x00000021. As a half-word read (`size` = 2'b01) it returns 0x0021 and loads zero into the holding register.
- R6: A half-word read whose address has bit 1 clear and bit 0 clear, at offset 0x000 or 0x010, returns the low 16 bits of that register in `rsp_data[15:0]` with zero upper bits. It also loads that register's upper 16 bits into the holding register.
- R7: A half-word read with address bit 1 set and bit 0 clear returns the holding register in `rsp_data[15:0]`, not a fresh sample of the count, with no error.
- R8: A word read, or a half-word read with address bit 1 clear, at any offset other than 0x000 or 0x010, gives `rsp_err` = 1 and zero data. The half-word form also loads zero into the holding register.
- R9: A write (`we` = 1) of any size gives `rsp_err` = 1 and zero data. It changes neither the count nor the holding register.
- R10: An access with `size` = 2'b00 (byte) or 2'b11, or a half-word access with address bit 0 set, gives `rsp_err` = 1 and zero data and leaves the holding register unchanged. `rsp_err` is never high without `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_async | input | 1 | 32.768 kHz tick level, asynchronous to `clk` |
| req | input | 1 | Access request, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| size | input | 2 | 00 byte, 01 half-word, 10 word, 11 reserved |
| addr | input | 12 | Byte offset of the access |
| rsp_valid | output | 1 | Response strobe, one cycle after `req` |
| rsp_data | output | 32 | Read data; zero on error |
| rsp_err | output | 1 | Error strobe, coincident with `rsp_valid` |

## Verification
A bus response is due exactly one clock after its request. The bench drives each request just after a falling edge and pushes the expected word into a queue in that same cycle. A monitor samples at the next falling edge, so a response that arrives early, late or missing shows up as a queue mismatch or as leftover entries. A tick edge passes through two synchronizer flops and an edge flop before the counter moves, so the bench leaves four idle clocks after the last tick before any read and keeps its expected count in its own model. The split-read case drives the count across 0xFFFF between a lower-half read and an upper-half read. This shows that the upper half comes from the holding register and not from the live count.

// File: rtl/stc_pkg.sv
package stc_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  typedef struct packed {
    logic        valid;
    logic        err;
    logic [31:0] data;
  } rsp_t;

endpackage

// File: rtl/stc_tick_sync.sv
module stc_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_async,
  output logic tick_pulse
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  // synchronizer chain, one flop per stage
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= 1'b0;
        else     chain_q[0] <= tick_async;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) chain_q[g] <= 1'b0;
        else     chain_q[g] <= chain_q[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain_q[STAGES-1];
  end

  assign tick_pulse = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/stc_counter.sv
module stc_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst)      count_q <= '0;
    else if (inc) count_q <= count_q + CNT_W'(1);
  end

  assign count = count_q;

endmodule

// File: rtl/stc_bus_decode.sv
module stc_bus_decode
  import stc_pkg::*;
#(
  parameter int              ADDR_W   = 12,
  parameter int              DATA_W   = 32,
  parameter logic [ADDR_W-1:0] REV_OFS = 'h000,
  parameter logic [ADDR_W-1:0] CNT_OFS = 'h010,
  parameter logic [DATA_W-1:0] REV_VAL = 'h21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] count,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_data,
  output logic [DATA_W/2-1:0] hold
);

  localparam int HALF_W = DATA_W / 2;

  acc_size_e         sz;
  logic              hit_rev;
  logic              hit_cnt;
  logic [DATA_W-1:0] reg_word;
  logic              nxt_err;
  logic [DATA_W-1:0] nxt_data;
  logic [HALF_W-1:0] nxt_hold;
  logic [HALF_W-1:0] hold_q;
  logic              valid_q;
  logic              err_q;
  logic [DATA_W-1:0] data_q;

  assign sz      = acc_size_e'(size);
  assign hit_rev = (addr == REV_OFS);
  assign hit_cnt = (addr == CNT_OFS);
  assign reg_word = hit_rev ? REV_VAL : (hit_cnt ? count : '0);

  always_comb begin
    nxt_err  = 1'b0;
    nxt_data = '0;
    nxt_hold = hold_q;
    if (req) begin
      if (we) begin
        nxt_err = 1'b1;
      end else begin
        unique case (sz)
          SZ_WORD: begin
            if (hit_rev || hit_cnt) nxt_data = reg_word;
            else                    nxt_err  = 1'b1;
          end
          SZ_HALF: begin
            if (addr[0]) begin
              nxt_err = 1'b1;
            end else if (addr[1]) begin
              nxt_data = {{HALF_W{1'b0}}, hold_q};
            end else begin
              nxt_hold = reg_word[DATA_W-1:HALF_W];
              if (hit_rev || hit_cnt) nxt_data = {{HALF_W{1'b0}}, reg_word[HALF_W-1:0]};
              else                    nxt_err  = 1'b1;
            end
          end
          default: nxt_err = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      data_q  <= '0;
      hold_q  <= '0;
    end else begin
      valid_q <= req;
      err_q   <= nxt_err;
      data_q  <= nxt_data;
      hold_q  <= nxt_hold;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_err   = err_q;
  assign rsp_data  = data_q;
  assign hold      = hold_q;

endmodule

// File: rtl/sync_tick_counter.sv
module sync_tick_counter #(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_async,
  input  logic              req,
  input  logic              we,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_err
);

  localparam int HALF_W = DATA_W / 2;

  logic              tick_pulse;
  logic [DATA_W-1:0] count_q;
  logic [HALF_W-1:0] hold_q;

  stc_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .tick_async (tick_async),
    .tick_pulse (tick_pulse)
  );

  stc_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .inc   (tick_pulse),
    .count (count_q)
  );

  stc_bus_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .we        (we),
    .size      (size),
    .addr      (addr),
    .count     (count_q),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_data  (rsp_data),
    .hold      (hold_q)
  );

endmodule

// File: rtl/stc_checker.sv
module stc_checker #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req,
  input logic              we,
  input logic [1:0]        size,
  input logic [ADDR_W-1:0] addr,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_data,
  input logic              rsp_err,
  input logic [DATA_W-1:0] count,
  input logic [DATA_W/2-1:0] hold
);

  p_reset_clear_r2: assert property (@(posedge clk)
    rst |=> (count == '0 && hold == '0 && !rsp_valid && !rsp_err));

  p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
    !$stable(count) |-> (count == $past(count) + DATA_W'(1)));

  p_rsp_follows_r3: assert property (@(posedge clk) disable iff (rst)
    req |=> rsp_valid);

  p_no_spurious_r3: assert property (@(posedge clk) disable iff (rst)
    !req |=> !rsp_valid);

  p_rev_word_r5: assert property (@(posedge clk) disable iff (rst)
    (req && !we && size == 2'b10 && addr == '0) |=> (rsp_data == DATA_W'(32'h21) && !rsp_err));

  p_err_zero_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_valid && rsp_data == '0));

  p_write_err_r9: assert property (@(posedge clk) disable iff (rst)
    (req && we) |=> (rsp_err && $stable(hold)));

  p_byte_err_r10: assert property (@(posedge clk) disable iff (rst)
    (req && !we && size == 2'b00) |=> (rsp_err && $stable(hold)));

endmodule

bind sync_tick_counter stc_checker i_chk (
  .clk       (clk),
  .rst       (rst),
  .req       (req),
  .we        (we),
  .size      (size),
  .addr      (addr),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data),
  .rsp_err   (rsp_err),
  .count     (count_q),
  .hold      (hold_q)
);

// File: tb/test_sync_tick_counter.sv
module test_sync_tick_counter;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  typedef struct {
    logic [31:0] data;
    logic        err;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_async = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  size = 2'b10;
  logic [11:0] addr = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        rsp_err;

  int   checks = 0;
  int   errors = 0;
  int   cnt_model = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_tick_counter i_sync_tick_counter (
    .clk        (clk),
    .rst        (rst),
    .tick_async (tick_async),
    .req        (req),
    .we         (we),
    .size       (size),
    .addr       (addr),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .rsp_err    (rsp_err)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one access, expected response queued for the monitor
  task automatic access(input bit w, input logic [1:0] sz, input logic [11:0] a,
                        input logic [31:0] ed, input bit ee, input string tag);
    exp_t e;
    @(negedge clk);
    req = 1'b1; we = w; size = sz; addr = a;
    e.data = ed; e.err = ee; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic ticks(input int n, input int hi, input int lo);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_async = 1'b1;
      repeat (hi - 1) @(negedge clk);
      @(negedge clk); tick_async = 1'b0;
      repeat (lo - 1) @(negedge clk);
    end
    cnt_model += n;
    repeat (4) @(negedge clk);
  endtask

  // monitor: pops expected responses as they come out
  always @(negedge clk) begin
    if (!rst) begin
      if (rsp_err && !rsp_valid)
        check(1'b0, "R10 err without valid", {31'd0, rsp_err}, 32'd0);
      if (rsp_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R3 response without request", rsp_data, 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(rsp_data == e.data, {e.tag, " data"}, rsp_data, e.data);
          check(rsp_err == e.err, {e.tag, " err"}, {31'd0, rsp_err}, {31'd0, e.err});
        end
      end
    end
  end

  initial begin
    for (int c = 0; c < WATCHDOG && !done; c++) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2: outputs held at zero in reset
    check(!rsp_valid && !rsp_err && rsp_data == 0, "R2 reset outputs", rsp_data, 32'd0);
    @(negedge clk); rst = 1'b0;
    repeat (2) @(negedge clk);
    check(!rsp_valid, "R3 idle no response", {31'd0, rsp_valid}, 32'd0);

    access(0, 2'b10, 12'h010, 32'd0, 0, "R2 count zero after reset");
    access(0, 2'b10, 12'h000, 32'h21, 0, "R5 revision word");
    access(0, 2'b01, 12'h000, 32'h0021, 0, "R5 revision half");
    access(0, 2'b01, 12'h002, 32'h0, 0, "R5 revision upper latched zero");

    ticks(5, 1, 1);
    access(0, 2'b10, 12'h010, cnt_model, 0, "R1 fast ticks");
    ticks(3, 9, 7);
    access(0, 2'b10, 12'h010, cnt_model, 0, "R1 long level counts once");
    access(0, 2'b01, 12'h010, cnt_model & 32'hFFFF, 0, "R6 half low");

    access(0, 2'b10, 12'h004, 32'd0, 1, "R8 unmapped word");
    access(0, 2'b10, 12'h011, 32'd0, 1, "R8 misaligned word");
    access(1, 2'b10, 12'h010, 32'd0, 1, "R9 write word");
    access(1, 2'b01, 12'h000, 32'd0, 1, "R9 write half");
    access(0, 2'b10, 12'h010, cnt_model, 0, "R9 count unchanged by write");

    // drive the count to just below a carry into bit 16
    ticks(32'hFFFE - cnt_model, 1, 1);
    access(0, 2'b01, 12'h010, 32'hFFFE, 0, "R6 half low before carry");
    ticks(3, 1, 1);
    access(0, 2'b01, 12'h012, 32'h0000, 0, "R7 upper from latch not live");
    access(0, 2'b10, 12'h010, 32'h0001_0001, 0, "R4 word after carry");
    access(0, 2'b01, 12'h010, 32'h0001, 0, "R6 half low after carry");
    access(0, 2'b01, 12'h012, 32'h0001, 0, "R7 latched upper");
    access(1, 2'b10, 12'h010, 32'd0, 1, "R9 write");
    access(0, 2'b01, 12'h012, 32'h0001, 0, "R9 latch kept after write");
    access(0, 2'b00, 12'h010, 32'd0, 1, "R10 byte read");
    access(0, 2'b11, 12'h010, 32'd0, 1, "R10 reserved size");
    access(0, 2'b01, 12'h013, 32'd0, 1, "R10 odd half address");
    access(0, 2'b01, 12'h012, 32'h0001, 0, "R10 latch kept after bad width");
    access(0, 2'b01, 12'h008, 32'd0, 1, "R8 unmapped half low");
    access(0, 2'b01, 12'h00A, 32'h0000, 0, "R8 latch zeroed by unmapped");

    // R2: reset restarts count and clears latch
    access(0, 2'b01, 12'h010, 32'h0001, 0, "R6 relatch before reset");
    repeat (2) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    cnt_model = 0;
    access(0, 2'b01, 12'h012, 32'h0000, 0, "R2 latch cleared");
    access(0, 2'b10, 12'h010, 32'd0, 0, "R2 count restarted");

    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R3 all responses seen", sb.size(), 32'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule